// File: doc/BRIEF.md
# Fixed-Frequency Current Chopper with Blanking Window

This block regulates the current in one or more motor coil channels by fixed-frequency chopping. A free-running frame counter splits time into chop frames of constant length. At the start of each frame an active-low sync strobe is held low for a programmable blanking window. While the strobe is low, every channel's drive latch is forced on.

Each channel has a set-dominant latch. The blanking window sets it. An over-current comparator input clears it once blanking has ended. The comparator is modelled as an asynchronous digital input and is passed through two flip-flops first. The latch gates that channel's two phase-select inputs onto its two MOSFET driver enables. When the latch is cleared, both enables of the channel drop together (fast decay). The outputs stay off until the next frame sets the latch again.

Because set wins over clear, the current spike that follows turn-on cannot end the on-time early. A global enable forces every driver enable low whatever state the latches are in.

Top module: `chop_regulator`

## Requirements
- R1: While reset is asserted, every driver enable is 0, the frame counter is at frame start, and `sync_n` is 0.
- R2: The chop frame lasts exactly PERIOD clock cycles. `sync_n` is 0 during the first B cycles of each frame and 1 for the rest, where B is the effective blanking length.
- R3: The effective blanking length B is `blank_len` limited to the range 1 to PERIOD-1: a value of 0 gives 1, and any value of PERIOD or more gives PERIOD-1.
- R4: In the clock cycle that follows the first blanking cycle of a frame, every channel's latch is set, so its driver enables follow its phase selects (with `en` high).
- R5: While `sync_n` is 0, a high comparator input does not clear a channel's latch (set dominates).
- R6: When `sync_n` is 1 and a channel's synchronised comparator is high, the latch clears on the next edge. It stays clear until the next blanking window.
- R7: The comparator input reaches the latch through two flip-flops. A comparator pulse that is high for one cycle, sampled at edge k, clears the latch at edge k+2, provided blanking is inactive at that time.
- R8: A cleared latch drives both enables of its channel to 0 (fast decay).
- R9: With the latch set and `en` high, `drv_en[2c]` equals `phase_sel[2c]` and `drv_en[2c+1]` equals `phase_sel[2c+1]`. Bit 2c is the phase signal and bit 2c+1 is its complement; no bits are swapped or reordered.
- R10: With `en` low, all driver enables are 0 in the same cycle, whatever the latch state.
- R11: Channels are independent. Comparator activity on one channel does not change another channel's enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable for all driver outputs |
| blank_len | input | CW | Requested blanking length in clock cycles |
| phase_sel | input | 2*NCH | Phase selects, two bits per channel (phase, complement) |
| ovc | input | NCH | Asynchronous over-current comparator, one bit per channel |
| sync_n | output | 1 | Active-low sync/blanking strobe |
| drv_en | output | 2*NCH | MOSFET driver enables, two bits per channel |

## Verification
Two functions can fall in the same cycle: the blanking set and the comparator clear. This happens when a channel's synchronised over-current is high while `sync_n` is low, including the wrap cycle where a clear and a new frame start meet. The bench provokes the collision by holding the comparator high across whole frames, and by firing random comparator activity against several blanking lengths, including the clamped extremes. The winner is judged at the driver enables: they must follow the phase selects for the whole blanking window and drop only in the cycle after blanking ends.

// File: rtl/chop_pkg.sv
package chop_pkg;

  // Effective blanking length: at least one cycle, always shorter than a frame.
  function automatic int unsigned blank_cycles(int unsigned req, int unsigned period);
    if (req == 0) return 1;
    if (req > period - 1) return period - 1;
    return req;
  endfunction

  // Next state of a set-dominant latch.
  function automatic logic sd_latch_next(logic set_i, logic clr_i, logic q);
    if (set_i) return 1'b1;
    if (clr_i) return 1'b0;
    return q;
  endfunction

endpackage

// File: rtl/chop_timebase.sv
module chop_timebase import chop_pkg::*; #(
  parameter int unsigned PERIOD = 250,
  parameter int unsigned CW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] blank_len,
  output logic [CW-1:0] cnt,
  output logic          blank_act
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] eff_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign eff_len   = CW'(blank_cycles(int'(blank_len), PERIOD));
  assign blank_act = (cnt < eff_len);
endmodule

// File: rtl/ovc_sync.sv
module ovc_sync #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ovc,
  output logic [NCH-1:0] ovc_s
);
  for (genvar c = 0; c < NCH; c++) begin : g_sync
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= ovc[c];
        stab_q <= meta_q;
      end
    end
    assign ovc_s[c] = stab_q;
  end
endmodule

// File: rtl/chop_channel.sv
module chop_channel import chop_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_i,
  input  logic       clr_i,
  input  logic       en,
  input  logic [1:0] phase,
  output logic       latch_q,
  output logic [1:0] drv
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= 1'b0;
    else        latch_q <= sd_latch_next(set_i, clr_i, latch_q);
  end

  // The latch acts as an inhibit on both outputs; phase order is untouched.
  assign drv = (en && latch_q) ? phase : 2'b00;
endmodule

// File: rtl/chop_regulator.sv
module chop_regulator #(
  parameter int unsigned NCH    = 2,
  parameter int unsigned PERIOD = 250,
  parameter int unsigned CW     = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CW-1:0]    blank_len,
  input  logic [2*NCH-1:0] phase_sel,
  input  logic [NCH-1:0]   ovc,
  output logic             sync_n,
  output logic [2*NCH-1:0] drv_en
);
  logic [CW-1:0]  cnt;
  logic           blank_act;
  logic [NCH-1:0] ovc_s;
  logic [NCH-1:0] latch_q;

  chop_timebase #(.PERIOD(PERIOD), .CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .blank_len(blank_len),
    .cnt(cnt), .blank_act(blank_act)
  );

  ovc_sync #(.NCH(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .ovc(ovc), .ovc_s(ovc_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chop_channel u_ch (
      .clk(clk), .rst_n(rst_n),
      .set_i(blank_act), .clr_i(ovc_s[c]), .en(en),
      .phase(phase_sel[2*c +: 2]),
      .latch_q(latch_q[c]), .drv(drv_en[2*c +: 2])
    );
  end

  assign sync_n = ~blank_act;
endmodule

// File: rtl/chop_regulator_chk.sv
module chop_regulator_chk #(
  parameter int unsigned NCH    = 2,
  parameter int unsigned PERIOD = 250,
  parameter int unsigned CW     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             sync_n,
  input logic [2*NCH-1:0] drv_en,
  input logic [CW-1:0]    cnt,
  input logic [NCH-1:0]   ovc_s,
  input logic [NCH-1:0]   latch_q
);
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CW'(PERIOD - 1) |=> cnt == '0); // R2

  AST_FRAME_START_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == '0 |-> !sync_n); // R3

  AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> drv_en == '0); // R10

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_SET_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_n |=> latch_q[c]); // R5

    AST_OVC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      sync_n && ovc_s[c] |=> !latch_q[c]); // R6

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      sync_n && !latch_q[c] |=> !latch_q[c]); // R6

    AST_FAST_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_q[c] |-> drv_en[2*c +: 2] == 2'b00); // R8
  end
endmodule

bind chop_regulator chop_regulator_chk #(.NCH(NCH), .PERIOD(PERIOD), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sync_n(sync_n), .drv_en(drv_en),
  .cnt(cnt), .ovc_s(ovc_s), .latch_q(latch_q)
);

// File: tb/sim_chop_regulator.sv
`timescale 1ns/1ps
module sim_chop_regulator;
  localparam int NCH = 2;
  localparam int PERIOD = 250;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [CW-1:0] blank_len = 8'd20;
  logic [2*NCH-1:0] phase_sel = '0;
  logic [NCH-1:0] ovc = '0;
  logic sync_n;
  logic [2*NCH-1:0] drv_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chop_regulator #(.NCH(NCH), .PERIOD(PERIOD), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .blank_len(blank_len),
    .phase_sel(phase_sel), .ovc(ovc), .sync_n(sync_n), .drv_en(drv_en)
  );

  // Reference model, written from the requirements.
  int m_pos;
  bit [NCH-1:0] m_d1, m_d2, m_on;

  function automatic int exp_blank(int req);
    int b;
    b = req;
    if (b < 1) b = 1;
    if (b >= PERIOD) b = PERIOD - 1;
    return b;
  endfunction

  function automatic bit exp_sync_n(int pos, int req);
    return !(pos < exp_blank(req));
  endfunction

  function automatic logic [2*NCH-1:0] exp_drv(bit [NCH-1:0] on, logic [2*NCH-1:0] ph, logic e);
    logic [2*NCH-1:0] r;
    r = '0;
    for (int c = 0; c < NCH; c++)
      if (e && on[c]) r[2*c +: 2] = ph[2*c +: 2];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos <= 0; m_d1 <= '0; m_d2 <= '0; m_on <= '0;
    end else begin
      bit blank;
      blank = !exp_sync_n(m_pos, int'(blank_len));
      m_pos <= (m_pos == PERIOD - 1) ? 0 : m_pos + 1;
      m_d1 <= ovc;
      m_d2 <= m_d1;
      for (int c = 0; c < NCH; c++)
        if (blank) m_on[c] <= 1'b1;
        else if (m_d2[c]) m_on[c] <= 1'b0;
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", req, got, exp, $time);
    end
  endtask

  // Compare every output at the falling edge, before inputs change.
  task automatic step();
    @(negedge clk);
    check("R2/R3 sync_n", 32'(sync_n), 32'(exp_sync_n(m_pos, int'(blank_len))));
    if (!en)            check("R10 drv_en", 32'(drv_en), 32'(0));
    else if (m_on == 0) check("R8 drv_en", 32'(drv_en), 32'(0));
    else                check("R9 drv_en", 32'(drv_en), 32'(exp_drv(m_on, phase_sel, en)));
  endtask

  task automatic go_to(int pos);
    do step(); while (m_pos != pos);
  endtask

  task automatic blank_width(int req, string tag);
    int lows;
    blank_len = CW'(req);
    go_to(PERIOD - 1);
    lows = 0;
    for (int i = 0; i < PERIOD; i++) begin
      step();
      if (!sync_n) lows++;
    end
    check(tag, 32'(lows), 32'(exp_blank(req)));
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    en = 1'b1;
    phase_sel = 4'b1001;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 drv_en", 32'(drv_en), 32'(0));
    check("R1 sync_n", 32'(sync_n), 32'(0));
    rst_n = 1'b1;

    // R4: latch set after first blanking cycle
    step();
    check("R4 on after frame start", 32'(drv_en), 32'(4'b1001));

    // R5 / R6: comparator held high across the frame
    blank_len = 8'd40;
    phase_sel = 4'b0101;
    go_to(PERIOD - 5);
    ovc = 2'b11;
    go_to(10);
    check("R5 blanked ovc ignored", 32'(drv_en), 32'(4'b0101));
    go_to(40);
    check("R5 last blank cycle", 32'(drv_en), 32'(4'b0101));
    step();
    check("R6 cleared after blank", 32'(drv_en), 32'(0));
    go_to(PERIOD - 1);
    check("R6 stays off", 32'(drv_en), 32'(0));
    ovc = 2'b00;
    go_to(5);

    // R7 / R11: single-cycle pulse on channel 0 only
    blank_len = 8'd20;
    go_to(100);
    ovc = 2'b01;
    step();
    ovc = 2'b00;
    step();
    check("R7 still on after two flops", 32'(drv_en), 32'(4'b0101));
    step();
    check("R7 channel 0 off", 32'(drv_en[1:0]), 32'(0));
    check("R11 channel 1 untouched", 32'(drv_en[3:2]), 32'(2'b01));
    go_to(1);
    check("R4 relatch next frame", 32'(drv_en), 32'(4'b0101));

    // R10: enable low
    en = 1'b0;
    step();
    check("R10 en low", 32'(drv_en), 32'(0));
    en = 1'b1;

    // R3: clamped blanking lengths, R2 frame width
    blank_width(0, "R3 min clamp");
    blank_width(255, "R3 max clamp");
    blank_width(77, "R2 nominal width");

    // Random phase: blanking, phases, comparator, enable
    for (int k = 0; k < 30; k++) begin
      blank_len = CW'($urandom_range(0, 255));
      for (int i = 0; i < 400; i++) begin
        step();
        if ($urandom_range(0, 15) == 0) phase_sel = 4'($urandom);
        ovc = NCH'($urandom_range(0, 3) == 0 ? $urandom : 0);
        en = ($urandom_range(0, 31) != 0);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule